// File: doc/BRIEF.md
# Two-Road Demand-Driven Green Light Controller

This block chooses which of two crossing roads, north-south or east-west, gets the green light. Each road has one green lamp and one red lamp. Exactly one road is green at any time. An internal interval timer fires a one-cycle decision tick once every decision period, which is thirty seconds of the system clock by default. The green moves to the other road only on that tick, and only when the detector on the other road reports a waiting car. When no car is waiting on the other road, the current green is held for as long as needed.

The car detectors are assumed to be already synchronised to the clock. The controller samples them only in the tick cycle, so a car that arrives and leaves between two ticks has no effect. The lamp outputs are decoded directly from the state register, as in a Moore machine. The machine has no amber phase: each lamp output is either green or red.

The period is set by `CLK_HZ` times `INTERVAL_S`. It can also be set directly through `TICKS`, which lets a testbench use a short period.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release, the north-south road is green, the east-west road is red, and the interval timer starts from zero.
- R2: In every cycle exactly one of `ns_green` and `ew_green` is high, and each red output is the inverse of the green output on the same road.
- R3: The lamp outputs change only on the clock edge that ends a tick cycle. On every other edge they hold their value.
- R4: When north-south is green and `car_ew` is high in the tick cycle, east-west becomes green after that edge, whatever the value of `car_ns`.
- R5: When east-west is green and `car_ns` is high in the tick cycle, north-south becomes green after that edge, whatever the value of `car_ew`.
- R6: When the detector on the road that is currently red is low in the tick cycle, the current green is kept.
- R7: Ticks occur every `TICKS` cycles. The first decision is taken on the `TICKS`-th rising edge after reset is released.
- R8: A detector pulse that begins and ends between two ticks does not change the lights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| car_ns | input | 1 | High while a car waits on the north-south road |
| car_ew | input | 1 | High while a car waits on the east-west road |
| ns_green | output | 1 | North-south green lamp |
| ns_red | output | 1 | North-south red lamp |
| ew_green | output | 1 | East-west green lamp |
| ew_red | output | 1 | East-west red lamp |

## Verification
In a tick cycle, two things happen on the same edge: the interval timer wraps, and the state register may take a new phase. Both detectors may also be high at that moment, so the hand-over rule and the "hold while the other road is empty" rule are tested at the same edge. The bench holds both detectors high across several intervals, which forces the green to alternate on each tick. It also injects detector pulses that end exactly one cycle before the tick. A bench model of the tick position judges every edge: a change is accepted only on the tick edge, and only toward a road that had a car waiting.

// File: rtl/xroad_pkg.sv
package xroad_pkg;
  // Phase encoding: index of the road that currently holds green.
  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_t;

  localparam int unsigned NUM_ROADS = 2;
endpackage

// File: rtl/decision_timer.sv
module decision_timer #(
  parameter int unsigned TICKS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // The tick is high in the cycle where the counter holds its last value.
  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
  import xroad_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   car_ns,
  input  logic   car_ew,
  output phase_t phase_q
);
  phase_t phase_d;

  // Next state: green goes to the other road only if a car waits there.
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_NS: if (car_ew) phase_d = PH_EW;
      PH_EW: if (car_ns) phase_d = PH_NS;
      default: phase_d = PH_NS;
    endcase
  end

  // The state register is clock-enabled by the decision tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= PH_NS;
    else if (tick) phase_q <= phase_d;
  end
endmodule

// File: rtl/lamp_decode.sv
module lamp_decode
  import xroad_pkg::*;
(
  input  phase_t                 phase,
  output logic [NUM_ROADS-1:0]   green,
  output logic [NUM_ROADS-1:0]   red
);
  for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
    always_comb begin
      green[r] = (phase == phase_t'(r));
      red[r]   = ~green[r];
    end
  end
endmodule

// File: rtl/xroad_light_ctrl.sv
module xroad_light_ctrl
  import xroad_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned INTERVAL_S = 30,
  parameter int unsigned TICKS      = CLK_HZ * INTERVAL_S
) (
  input  logic clk,
  input  logic rst_n,
  input  logic car_ns,
  input  logic car_ew,
  output logic ns_green,
  output logic ns_red,
  output logic ew_green,
  output logic ew_red
);
  logic                 tick;
  phase_t               phase;
  logic [NUM_ROADS-1:0] green;
  logic [NUM_ROADS-1:0] red;

  decision_timer #(.TICKS(TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  phase_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .car_ns  (car_ns),
    .car_ew  (car_ew),
    .phase_q (phase)
  );

  lamp_decode u_lamps (
    .phase (phase),
    .green (green),
    .red   (red)
  );

  // Road index 0 is north-south and road index 1 is east-west.
  assign ns_green = green[0];
  assign ns_red   = red[0];
  assign ew_green = green[1];
  assign ew_red   = red[1];
endmodule

// File: rtl/xroad_light_chk.sv
module xroad_light_chk #(
  parameter int unsigned TICKS = 1500
) (
  input logic clk,
  input logic rst_n,
  input logic car_ns,
  input logic car_ew,
  input logic ns_green,
  input logic ns_red,
  input logic ew_green,
  input logic ew_red
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;

  // The checker keeps its own count of where the decision window is.
  logic [CW-1:0] win_q;
  logic          at_tick;
  assign at_tick = (win_q == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       win_q <= '0;
    else if (at_tick) win_q <= '0;
    else              win_q <= win_q + 1'b1;
  end

  AST_ONE_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ns_green, ew_green}) == 1); // R2
  AST_RED_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_red != ns_green) && (ew_red != ew_green)); // R2
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !at_tick |=> $stable(ns_green) && $stable(ew_green)); // R3
  AST_NS_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (at_tick && ns_green && car_ew) |=> ew_green); // R4
  AST_EW_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (at_tick && ew_green && car_ns) |=> ns_green); // R5
  AST_NS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_tick && ns_green && !car_ew) |=> ns_green); // R6
  AST_EW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_tick && ew_green && !car_ns) |=> ew_green); // R6
endmodule

bind xroad_light_ctrl xroad_light_chk #(.TICKS(TICKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .car_ns   (car_ns),
  .car_ew   (car_ew),
  .ns_green (ns_green),
  .ns_red   (ns_red),
  .ew_green (ew_green),
  .ew_red   (ew_red)
);

// File: tb/tb_xroad_light_ctrl.sv
module tb_xroad_light_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TB_TICKS   = 8;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic car_ns = 1'b0;
  logic car_ew = 1'b0;
  logic ns_green, ns_red, ew_green, ew_red;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench reference: m_phase 0 = north-south green, 1 = east-west green.
  bit    m_phase = 1'b0;
  int    m_cnt = 0;
  string m_tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  xroad_light_ctrl #(.TICKS(TB_TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .car_ns(car_ns), .car_ew(car_ew),
    .ns_green(ns_green), .ns_red(ns_red), .ew_green(ew_green), .ew_red(ew_red)
  );

  function automatic bit exp_green(bit phase, int road);
    return (road == 0) ? (phase == 1'b0) : (phase == 1'b1);
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_lamps(string tag);
    check(tag, "ns_green", ns_green, exp_green(m_phase, 0));
    check(tag, "ew_green", ew_green, exp_green(m_phase, 1));
    check("R2", "ns_red", ns_red, ~ns_green);
    check("R2", "ew_red", ew_red, ~ew_green);
    check("R2", "one_green", ns_green ^ ew_green, 1'b1);
  endtask

  // One clock: update the reference at the edge, then check at the falling edge.
  task automatic run_cycle();
    @(posedge clk);
    if (m_cnt == TB_TICKS - 1) begin
      if (m_phase == 1'b0) m_tag = car_ew ? "R4" : "R6";
      else                 m_tag = car_ns ? "R5" : "R6";
      if (m_phase == 1'b0 && car_ew)      m_phase = 1'b1;
      else if (m_phase == 1'b1 && car_ns) m_phase = 1'b0;
      m_cnt = 0;
    end else begin
      m_tag = "R3";
      m_cnt++;
    end
    @(negedge clk);
    check_lamps(m_tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD * 2);
    @(negedge clk);
    check("R1", "ns_green in reset", ns_green, 1'b1);
    check("R1", "ew_green in reset", ew_green, 1'b0);
    m_phase = 1'b0;
    m_cnt = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    car_ns = 1'b0;
    car_ew = 1'b0;
    do_reset();

    // R7: with a car waiting on east-west, the first hand-over is on edge TB_TICKS.
    begin
      int first_sw = 0;
      car_ew = 1'b1;
      for (int n = 1; n <= TB_TICKS + 2; n++) begin
        run_cycle();
        if (ew_green && first_sw == 0) first_sw = n;
      end
      check("R7", "first decision edge", (first_sw == TB_TICKS), 1'b1);
    end
    car_ew = 1'b0;

    // R8: a north-south pulse that ends one cycle before the tick is ignored.
    while (m_cnt != 0) run_cycle();
    for (int n = 0; n < TB_TICKS; n++) begin
      car_ns = (m_cnt != TB_TICKS - 1);
      run_cycle();
    end
    check("R8", "ew keeps green after pulse", ew_green, 1'b1);
    car_ns = 1'b0;

    // R6: with no cars at all, the green is held across several intervals.
    for (int n = 0; n < 3 * TB_TICKS; n++) run_cycle();
    check("R6", "ew held with no cars", ew_green, 1'b1);

    // R4/R5: both detectors high, so the green alternates on every tick.
    car_ns = 1'b1;
    car_ew = 1'b1;
    for (int n = 0; n < 4 * TB_TICKS; n++) run_cycle();
    car_ns = 1'b0;
    car_ew = 1'b0;

    // R1: a reset in the middle of the run restores north-south green.
    do_reset();
    run_cycle();
    check("R1", "ns green after release", ns_green, 1'b1);

    // Random detector traffic, with cars waiting about one third of the time.
    for (int n = 0; n < 3000; n++) begin
      car_ns = ($urandom % 3 == 0);
      car_ew = ($urandom % 3 == 0);
      run_cycle();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule